// File: doc/BRIEF.md
# System Control Register Interface

This block holds the configuration registers of a processor's system-control coprocessor and decodes the instruction words that move values into and out of it. The pipeline presents a 32-bit instruction word, a direction flag and, for writes, the value taken from a general register. The block picks out the register-select fields of the word and stores the value, returns a stored value for write-back to a general register, or turns the command into a one-cycle invalidate pulse for the cache or the TLB.

Seven registers are held: identification, cache type, control, translation table base, domain, fault status and fault address. A memory unit can load fault status and fault address together through a dedicated capture port, and this port wins over software. Three bits of the control register drive the enables of the translation unit, the alignment checker and the cache. All responses are registered and appear in the cycle after the command.

Top module: `sysctl_regif`

## Requirements
- R1: Instruction word fields are op1 = bits 23:21, crn = bits 19:16, rd = bits 15:12, op2 = bits 7:5 and crm = bits 3:0. No other bit of the word affects behaviour. `cmd_is_read` = 1 marks a read and 0 marks a write.
- R2: A write whose op1 is nonzero or whose rd is 15 is dropped. No register changes, and no pulse, strobe or undefined flag follows.
- R3: A read whose op1 is nonzero, whose rd is 15 or whose crm is nonzero is dropped. No `rd_valid` and no `undef_access` follows.
- R4: After reset, control holds 0x00000070, identification holds `ID_RESET`, cache type holds `CTYPE_RESET`, and translation base, domain, fault status and fault address hold zero.
- R5: Register select: crn 0 with op2 0 picks identification and crn 0 with op2 1 picks cache type. crn 1, 2, 3, 5 and 6 pick control, translation base, domain, fault status and fault address. An accepted write stores `cmd_wdata`, and the new value can be read from the next cycle. crn 0 with any other op2 stores nothing.
- R6: An accepted read with a defined crn gives, in the next cycle, `rd_valid` high for one cycle, `rd_index` equal to rd, and `rd_data` equal to the selected register as it stood before that command's clock edge. crn 0 with op2 other than 0 or 1 returns zero.
- R7: An accepted write with crn 7 and op2 0 raises `cache_inv_all` for one cycle in the next cycle and stores nothing. Other op2 values with crn 7 do nothing.
- R8: An accepted write with crn 8 raises `tlb_inv_all` when op2 is 0. With op2 equal to 1 it raises `tlb_inv_one`, and `tlb_inv_addr` carries `cmd_wdata`. In both cases the pulse is one cycle long, in the next cycle, and nothing is stored.
- R9: An accepted write with crn 4 or 9 to 15, or an accepted read with crn 4 or 7 to 15, raises `undef_access` for one cycle in the next cycle and changes no register.
- R10: When `flt_valid` is high at a clock edge, fault status loads `flt_status` and fault address loads `flt_addr`. This overrides a software write to either register at the same edge.
- R11: `mmu_en`, `align_chk_en` and `cache_en` equal control bits 0, 1 and 2.
- R12: At most one of `rd_valid`, `undef_access`, `cache_inv_all`, `tlb_inv_all` and `tlb_inv_one` is high in any cycle. All of them are low in the cycle after a cycle with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_is_read | input | 1 | 1 = read from coprocessor, 0 = write to it |
| cmd_word | input | 32 | Coprocessor instruction word |
| cmd_wdata | input | 32 | General-register value for writes |
| flt_valid | input | 1 | Fault capture request |
| flt_status | input | 32 | Fault status to capture |
| flt_addr | input | 32 | Fault address to capture |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_index | output | 4 | Destination general register of the read |
| rd_data | output | 32 | Read result |
| undef_access | output | 1 | Unsupported register number (one cycle) |
| cache_inv_all | output | 1 | Invalidate entire cache (one cycle) |
| tlb_inv_all | output | 1 | Invalidate whole TLB (one cycle) |
| tlb_inv_one | output | 1 | Invalidate one TLB entry (one cycle) |
| tlb_inv_addr | output | 32 | Address for the single-entry invalidate |
| mmu_en | output | 1 | Translation enable, control bit 0 |
| align_chk_en | output | 1 | Alignment check enable, control bit 1 |
| cache_en | output | 1 | Cache enable, control bit 2 |

## Verification
The properties assume that `cmd_is_read` is meaningful only while `cmd_valid` is high. They also assume that a fault capture never changes the control register, so the enable outputs may be held stable across a dropped or undefined command. The bench drives one command per cycle at the falling edge and sweeps every crn and op2 pair in both directions with an accepted encoding. It then walks the rejection encodings one field at a time, so each stimulus targets a single acceptance rule. Fault captures are applied both alone and on the same edge as a software write to the fault registers.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned OP1_LSB = 21;
  localparam int unsigned OP1_W   = 3;
  localparam int unsigned CRN_LSB = 16;
  localparam int unsigned CRN_W   = 4;
  localparam int unsigned RD_LSB  = 12;
  localparam int unsigned RD_W    = 4;
  localparam int unsigned OP2_LSB = 5;
  localparam int unsigned OP2_W   = 3;
  localparam int unsigned CRM_LSB = 0;
  localparam int unsigned CRM_W   = 4;

  localparam logic [RD_W-1:0]   RD_FORBIDDEN = '1;
  localparam logic [WORD_W-1:0] CTRL_RESET   = 32'h0000_0070;

  localparam int unsigned MMU_EN_BIT   = 0;
  localparam int unsigned ALIGN_EN_BIT = 1;
  localparam int unsigned CACHE_EN_BIT = 2;

  // Register selector; zero means nothing is stored or returned.
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_ID    = 3'd1,
    SEL_CTYPE = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_TTB   = 3'd4,
    SEL_DOM   = 3'd5,
    SEL_FSR   = 3'd6,
    SEL_FAR   = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_REGS  = 7;
  localparam int unsigned CTRL_SLOT = 2;

  typedef struct packed {
    logic [OP1_W-1:0] op1;
    logic [CRN_W-1:0] crn;
    logic [RD_W-1:0]  rd;
    logic [OP2_W-1:0] op2;
    logic [CRM_W-1:0] crm;
  } cop_fields_t;

  function automatic cop_fields_t split_word(input logic [WORD_W-1:0] w);
    cop_fields_t f;
    f.op1 = w[OP1_LSB +: OP1_W];
    f.crn = w[CRN_LSB +: CRN_W];
    f.rd  = w[RD_LSB  +: RD_W];
    f.op2 = w[OP2_LSB +: OP2_W];
    f.crm = w[CRM_LSB +: CRM_W];
    return f;
  endfunction

  function automatic logic write_blocked(input cop_fields_t f);
    return (f.op1 != '0) || (f.rd == RD_FORBIDDEN);
  endfunction

  function automatic logic read_blocked(input cop_fields_t f);
    return write_blocked(f) || (f.crm != '0);
  endfunction

  function automatic logic crn_defined(input logic [CRN_W-1:0] crn, input logic is_read);
    logic ok;
    case (crn)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6: ok = 1'b1;
      4'd7, 4'd8:                         ok = !is_read;
      default:                            ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic reg_sel_e reg_for(input cop_fields_t f);
    reg_sel_e s;
    case (f.crn)
      4'd0: begin
        if (f.op2 == 3'd0)      s = SEL_ID;
        else if (f.op2 == 3'd1) s = SEL_CTYPE;
        else                    s = SEL_NONE;
      end
      4'd1:    s = SEL_CTRL;
      4'd2:    s = SEL_TTB;
      4'd3:    s = SEL_DOM;
      4'd5:    s = SEL_FSR;
      4'd6:    s = SEL_FAR;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] reset_value_of(input reg_sel_e s,
                                                       input logic [WORD_W-1:0] id_v,
                                                       input logic [WORD_W-1:0] ct_v);
    logic [WORD_W-1:0] v;
    case (s)
      SEL_ID:    v = id_v;
      SEL_CTYPE: v = ct_v;
      SEL_CTRL:  v = CTRL_RESET;
      default:   v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic              cmd_valid,
  input  logic              cmd_is_read,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              wr_en,
  output logic              rd_en,
  output reg_sel_e          sel,
  output logic [RD_W-1:0]   rd_idx,
  output logic              undef,
  output logic              inv_cache,
  output logic              inv_tlb_all,
  output logic              inv_tlb_one
);

  cop_fields_t f;
  logic        accepted;
  logic        known;
  logic        unused_bits;

  assign unused_bits = ^{cmd_word[31:24], cmd_word[20], cmd_word[11:8], cmd_word[4]};

  always_comb begin
    f        = split_word(cmd_word);
    accepted = cmd_valid && !(cmd_is_read ? read_blocked(f) : write_blocked(f));
    known    = crn_defined(f.crn, cmd_is_read);
    sel      = reg_for(f);
    rd_idx   = f.rd;
    wr_en       = accepted && !cmd_is_read && known && (sel != SEL_NONE);
    rd_en       = accepted && cmd_is_read && known;
    undef       = accepted && !known;
    inv_cache   = accepted && !cmd_is_read && (f.crn == 4'd7) && (f.op2 == 3'd0);
    inv_tlb_all = accepted && !cmd_is_read && (f.crn == 4'd8) && (f.op2 == 3'd0);
    inv_tlb_one = accepted && !cmd_is_read && (f.crn == 4'd8) && (f.op2 == 3'd1);
  end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_RESET    = 32'h0000_0000,
  parameter logic [WORD_W-1:0] CTYPE_RESET = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              flt_valid,
  input  logic [WORD_W-1:0] flt_status,
  input  logic [WORD_W-1:0] flt_addr,
  input  reg_sel_e          rd_sel,
  output logic [WORD_W-1:0] rd_value,
  output logic              mmu_en,
  output logic              align_en,
  output logic              cache_en
);

  logic [NUM_REGS-1:0][WORD_W-1:0] slot_flat;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    localparam reg_sel_e          CODE = reg_sel_e'(3'(i + 1));
    localparam logic [WORD_W-1:0] RST  = reset_value_of(CODE, ID_RESET, CTYPE_RESET);
    logic              hw_load;
    logic [WORD_W-1:0] hw_val;
    logic [WORD_W-1:0] q;

    if (CODE == SEL_FSR || CODE == SEL_FAR) begin : g_hw
      assign hw_load = flt_valid;
      assign hw_val  = (CODE == SEL_FSR) ? flt_status : flt_addr;
    end else begin : g_sw
      assign hw_load = 1'b0;
      assign hw_val  = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= RST;
      else if (hw_load)                  q <= hw_val;
      else if (wr_en && wr_sel == CODE)  q <= wr_data;
    end

    assign slot_flat[i] = q;
  end

  always_comb begin
    rd_value = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_sel == reg_sel_e'(3'(k + 1))) rd_value = slot_flat[k];
    end
  end

  assign mmu_en   = slot_flat[CTRL_SLOT][MMU_EN_BIT];
  assign align_en = slot_flat[CTRL_SLOT][ALIGN_EN_BIT];
  assign cache_en = slot_flat[CTRL_SLOT][CACHE_EN_BIT];

endmodule

// File: rtl/sysctl_resp.sv
module sysctl_resp
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [RD_W-1:0]   rd_idx,
  input  logic [WORD_W-1:0] rd_value,
  input  logic              undef,
  input  logic              inv_cache,
  input  logic              inv_tlb_all,
  input  logic              inv_tlb_one,
  input  logic [WORD_W-1:0] wdata,
  output logic              rd_valid,
  output logic [RD_W-1:0]   rd_index,
  output logic [WORD_W-1:0] rd_data,
  output logic              undef_q,
  output logic              cache_inv_q,
  output logic              tlb_all_q,
  output logic              tlb_one_q,
  output logic [WORD_W-1:0] tlb_addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_index    <= '0;
      rd_data     <= '0;
      undef_q     <= 1'b0;
      cache_inv_q <= 1'b0;
      tlb_all_q   <= 1'b0;
      tlb_one_q   <= 1'b0;
      tlb_addr_q  <= '0;
    end else begin
      rd_valid    <= rd_en;
      rd_index    <= rd_en ? rd_idx : '0;
      rd_data     <= rd_en ? rd_value : '0;
      undef_q     <= undef;
      cache_inv_q <= inv_cache;
      tlb_all_q   <= inv_tlb_all;
      tlb_one_q   <= inv_tlb_one;
      tlb_addr_q  <= inv_tlb_one ? wdata : '0;
    end
  end

endmodule

// File: rtl/sysctl_regif.sv
module sysctl_regif
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_RESET    = 32'h4100_7200,
  parameter logic [31:0] CTYPE_RESET = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_is_read,
  input  logic [31:0] cmd_word,
  input  logic [31:0] cmd_wdata,
  input  logic        flt_valid,
  input  logic [31:0] flt_status,
  input  logic [31:0] flt_addr,
  output logic        rd_valid,
  output logic [3:0]  rd_index,
  output logic [31:0] rd_data,
  output logic        undef_access,
  output logic        cache_inv_all,
  output logic        tlb_inv_all,
  output logic        tlb_inv_one,
  output logic [31:0] tlb_inv_addr,
  output logic        mmu_en,
  output logic        align_chk_en,
  output logic        cache_en
);

  // Decoder events, brought out by name for the checker.
  logic            dec_wr_en;
  logic            dec_rd_en;
  reg_sel_e        dec_sel;
  logic [RD_W-1:0] dec_rd_idx;
  logic            dec_undef;
  logic            dec_inv_cache;
  logic            dec_inv_tlb_all;
  logic            dec_inv_tlb_one;
  logic [WORD_W-1:0] bank_rd_value;

  sysctl_decode u_decode (
    .cmd_valid   (cmd_valid),
    .cmd_is_read (cmd_is_read),
    .cmd_word    (cmd_word),
    .wr_en       (dec_wr_en),
    .rd_en       (dec_rd_en),
    .sel         (dec_sel),
    .rd_idx      (dec_rd_idx),
    .undef       (dec_undef),
    .inv_cache   (dec_inv_cache),
    .inv_tlb_all (dec_inv_tlb_all),
    .inv_tlb_one (dec_inv_tlb_one)
  );

  sysctl_regbank #(
    .ID_RESET    (ID_RESET),
    .CTYPE_RESET (CTYPE_RESET)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (dec_wr_en),
    .wr_sel     (dec_sel),
    .wr_data    (cmd_wdata),
    .flt_valid  (flt_valid),
    .flt_status (flt_status),
    .flt_addr   (flt_addr),
    .rd_sel     (dec_rd_en ? dec_sel : SEL_NONE),
    .rd_value   (bank_rd_value),
    .mmu_en     (mmu_en),
    .align_en   (align_chk_en),
    .cache_en   (cache_en)
  );

  sysctl_resp u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (dec_rd_en),
    .rd_idx      (dec_rd_idx),
    .rd_value    (bank_rd_value),
    .undef       (dec_undef),
    .inv_cache   (dec_inv_cache),
    .inv_tlb_all (dec_inv_tlb_all),
    .inv_tlb_one (dec_inv_tlb_one),
    .wdata       (cmd_wdata),
    .rd_valid    (rd_valid),
    .rd_index    (rd_index),
    .rd_data     (rd_data),
    .undef_q     (undef_access),
    .cache_inv_q (cache_inv_all),
    .tlb_all_q   (tlb_inv_all),
    .tlb_one_q   (tlb_inv_one),
    .tlb_addr_q  (tlb_inv_addr)
  );

endmodule

// File: rtl/sysctl_regif_chk.sv
module sysctl_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_is_read,
  input logic [31:0] cmd_word,
  input logic [31:0] cmd_wdata,
  input logic        dec_undef,
  input logic        rd_valid,
  input logic [3:0]  rd_index,
  input logic        undef_access,
  input logic        cache_inv_all,
  input logic        tlb_inv_all,
  input logic        tlb_inv_one,
  input logic [31:0] tlb_inv_addr,
  input logic        mmu_en,
  input logic        align_chk_en,
  input logic        cache_en
);

  logic [2:0] c_op1;
  logic [3:0] c_crn;
  logic [3:0] c_rd;
  logic [2:0] c_op2;
  logic [3:0] c_crm;
  logic       wr_ok, rd_ok, wr_drop, rd_drop, rd_good, wr_undef, rd_undef;
  logic [4:0] events;
  logic [2:0] enables;

  assign c_op1 = cmd_word[23:21];
  assign c_crn = cmd_word[19:16];
  assign c_rd  = cmd_word[15:12];
  assign c_op2 = cmd_word[7:5];
  assign c_crm = cmd_word[3:0];

  assign wr_ok    = cmd_valid && !cmd_is_read && c_op1 == 3'd0 && c_rd != 4'd15;
  assign rd_ok    = cmd_valid && cmd_is_read && c_op1 == 3'd0 && c_rd != 4'd15 && c_crm == 4'd0;
  assign wr_drop  = cmd_valid && !cmd_is_read && !wr_ok;
  assign rd_drop  = cmd_valid && cmd_is_read && !rd_ok;
  assign rd_good  = rd_ok && (c_crn inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6});
  assign wr_undef = wr_ok && (c_crn == 4'd4 || c_crn > 4'd8);
  assign rd_undef = rd_ok && (c_crn == 4'd4 || c_crn > 4'd6);
  assign events   = {rd_valid, undef_access, cache_inv_all, tlb_inv_all, tlb_inv_one};
  assign enables  = {cache_en, align_chk_en, mmu_en};

  p_one_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(events));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> events == 5'd0);

  p_wr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> events == 5'd0 && $stable(enables));

  p_rd_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drop |=> !rd_valid && !undef_access);

  p_rd_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_good |=> rd_valid && rd_index == $past(c_rd));

  p_cache_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && c_crn == 4'd7 && c_op2 == 3'd0) |=> cache_inv_all);

  p_tlb_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && c_crn == 4'd8 && c_op2 == 3'd1) |=> tlb_inv_one && tlb_inv_addr == $past(cmd_wdata));

  p_tlb_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && c_crn == 4'd8 && c_op2 == 3'd0) |=> tlb_inv_all && !tlb_inv_one);

  p_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_undef || rd_undef) |=> undef_access && $stable(enables));

  p_undef_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_undef |-> (wr_undef || rd_undef));

endmodule

bind sysctl_regif sysctl_regif_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_is_read   (cmd_is_read),
  .cmd_word      (cmd_word),
  .cmd_wdata     (cmd_wdata),
  .dec_undef     (dec_undef),
  .rd_valid      (rd_valid),
  .rd_index      (rd_index),
  .undef_access  (undef_access),
  .cache_inv_all (cache_inv_all),
  .tlb_inv_all   (tlb_inv_all),
  .tlb_inv_one   (tlb_inv_one),
  .tlb_inv_addr  (tlb_inv_addr),
  .mmu_en        (mmu_en),
  .align_chk_en  (align_chk_en),
  .cache_en      (cache_en)
);

// File: tb/sysctl_regif_bench.sv
`timescale 1ns/1ps
module sysctl_regif_bench;

  localparam logic [31:0] ID_VAL = 32'h4E53_0720;
  localparam logic [31:0] CT_VAL = 32'h1C19_2192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_is_read = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [31:0] cmd_wdata = '0;
  logic        flt_valid = 1'b0;
  logic [31:0] flt_status = '0;
  logic [31:0] flt_addr = '0;
  logic        rd_valid;
  logic [3:0]  rd_index;
  logic [31:0] rd_data;
  logic        undef_access, cache_inv_all, tlb_inv_all, tlb_inv_one;
  logic [31:0] tlb_inv_addr;
  logic        mmu_en, align_chk_en, cache_en;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_id, m_ct, m_ctrl, m_ttb, m_dom, m_fsr, m_far;

  always #4 clk = ~clk;

  sysctl_regif #(.ID_RESET(ID_VAL), .CTYPE_RESET(CT_VAL)) u_sysctl_regif (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read),
    .cmd_word(cmd_word), .cmd_wdata(cmd_wdata), .flt_valid(flt_valid),
    .flt_status(flt_status), .flt_addr(flt_addr), .rd_valid(rd_valid),
    .rd_index(rd_index), .rd_data(rd_data), .undef_access(undef_access),
    .cache_inv_all(cache_inv_all), .tlb_inv_all(tlb_inv_all), .tlb_inv_one(tlb_inv_one),
    .tlb_inv_addr(tlb_inv_addr), .mmu_en(mmu_en), .align_chk_en(align_chk_en),
    .cache_en(cache_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Junk in the bits outside the named fields (R1: they must not matter).
  function automatic logic [31:0] mk(input logic [2:0] op1, input logic [3:0] crn,
                                     input logic [3:0] rd, input logic [2:0] op2,
                                     input logic [3:0] crm);
    return {8'hEE, op1, 1'b1, crn, rd, 4'hB, op2, 1'b1, crm};
  endfunction

  function automatic logic [31:0] model_rd(input logic [3:0] crn, input logic [2:0] op2);
    case (crn)
      4'd0: return (op2 == 3'd0) ? m_id : (op2 == 3'd1) ? m_ct : 32'd0;
      4'd1: return m_ctrl;
      4'd2: return m_ttb;
      4'd3: return m_dom;
      4'd5: return m_fsr;
      4'd6: return m_far;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input bit rd, input logic [3:0] crn);
    if (rd) return (crn == 4'd4 || crn > 4'd6) ? "R9" : "R6";
    if (crn == 4'd7) return "R7";
    if (crn == 4'd8) return "R8";
    if (crn == 4'd4 || crn > 4'd8) return "R9";
    return "R5";
  endfunction

  task automatic do_cmd(input bit cv, input bit rd, input logic [2:0] op1, input logic [3:0] crn,
                        input logic [3:0] rdi, input logic [2:0] op2, input logic [3:0] crm,
                        input logic [31:0] wd, input bit fv, input logic [31:0] fs,
                        input logic [31:0] fa, input string tag);
    bit acc, known, e_rv, e_un, e_ci, e_ta, e_to;
    logic [31:0] e_data, e_addr;
    logic [3:0]  e_idx;
    logic [79:0] act, exp;
    acc   = cv && op1 == 3'd0 && rdi != 4'd15 && (!rd || crm == 4'd0);
    known = rd ? (crn inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6})
               : (crn inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd8});
    e_rv   = acc && rd && known;
    e_un   = acc && !known;
    e_ci   = acc && !rd && crn == 4'd7 && op2 == 3'd0;
    e_ta   = acc && !rd && crn == 4'd8 && op2 == 3'd0;
    e_to   = acc && !rd && crn == 4'd8 && op2 == 3'd1;
    e_addr = e_to ? wd : 32'd0;
    e_data = e_rv ? model_rd(crn, op2) : 32'd0;
    e_idx  = e_rv ? rdi : 4'd0;
    cmd_valid = cv; cmd_is_read = rd; cmd_word = mk(op1, crn, rdi, op2, crm); cmd_wdata = wd;
    flt_valid = fv; flt_status = fs; flt_addr = fa;
    if (acc && !rd && known) begin
      case (crn)
        4'd0: begin if (op2 == 3'd0) m_id = wd; else if (op2 == 3'd1) m_ct = wd; end
        4'd1: m_ctrl = wd;
        4'd2: m_ttb = wd;
        4'd3: m_dom = wd;
        4'd5: m_fsr = wd;
        4'd6: m_far = wd;
        default: ;
      endcase
    end
    if (fv) begin m_fsr = fs; m_far = fa; end
    @(negedge clk);
    act = {rd_valid, undef_access, cache_inv_all, tlb_inv_all, tlb_inv_one, 7'd0, rd_index, rd_data, tlb_inv_addr};
    exp = {e_rv, e_un, e_ci, e_ta, e_to, 7'd0, e_idx, e_data, e_addr};
    chk(act == exp, tag, act, exp);
    chk({cache_en, align_chk_en, mmu_en} == m_ctrl[2:0], "R11",
        80'({cache_en, align_chk_en, mmu_en}), 80'(m_ctrl[2:0]));
    cmd_valid = 1'b0; flt_valid = 1'b0;
  endtask

  initial begin
    m_id = ID_VAL; m_ct = CT_VAL; m_ctrl = 32'h70;
    m_ttb = 0; m_dom = 0; m_fsr = 0; m_far = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 idle and R4 reset state (enables low)
    do_cmd(0, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0, 0, "R12");
    do_cmd(1, 1, 0, 4'd0, 4'd1, 3'd0, 0, 0, 0, 0, 0, "R4");
    do_cmd(1, 1, 0, 4'd0, 4'd2, 3'd1, 0, 0, 0, 0, 0, "R4");
    do_cmd(1, 1, 0, 4'd1, 4'd3, 3'd0, 0, 0, 0, 0, 0, "R4");
    do_cmd(1, 1, 0, 4'd2, 4'd4, 3'd0, 0, 0, 0, 0, 0, "R4");
    do_cmd(1, 1, 0, 4'd3, 4'd5, 3'd0, 0, 0, 0, 0, 0, "R4");
    do_cmd(1, 1, 0, 4'd5, 4'd6, 3'd0, 0, 0, 0, 0, 0, "R4");
    do_cmd(1, 1, 0, 4'd6, 4'd7, 3'd0, 0, 0, 0, 0, 0, "R4");
    // R1: destination index and field placement
    do_cmd(1, 1, 0, 4'd1, 4'd14, 3'd0, 0, 0, 0, 0, 0, "R1");
    do_cmd(1, 1, 0, 4'd1, 4'd0, 3'd0, 0, 0, 0, 0, 0, "R1");
    // Sweep every crn/op2 pair: write, then read back
    for (int c = 0; c < 16; c++) begin
      for (int o = 0; o < 8; o++) begin
        logic [31:0] v;
        v = {8'h5A, 12'h000, 4'(c), 5'd0, 3'(o)};
        do_cmd(1, 0, 0, 4'(c), 4'(o + 1), 3'(o), 4'(o), v, 0, 0, 0, tag_of(0, 4'(c)));
        do_cmd(1, 1, 0, 4'(c), 4'(c % 15), 3'(o), 0, 0, 0, 0, 0, tag_of(1, 4'(c)));
      end
    end
    // R2: dropped writes, then read back unchanged control
    do_cmd(1, 0, 3'd1, 4'd1, 4'd2, 0, 0, 32'h7, 0, 0, 0, "R2");
    do_cmd(1, 0, 3'd7, 4'd8, 4'd2, 3'd1, 0, 32'h9, 0, 0, 0, "R2");
    do_cmd(1, 0, 0, 4'd1, 4'd15, 0, 0, 32'h5, 0, 0, 0, "R2");
    do_cmd(1, 0, 0, 4'd7, 4'd15, 0, 0, 32'h5, 0, 0, 0, "R2");
    do_cmd(1, 1, 0, 4'd1, 4'd2, 0, 0, 0, 0, 0, 0, "R2");
    // R3: dropped reads
    do_cmd(1, 1, 0, 4'd1, 4'd2, 0, 4'd3, 0, 0, 0, 0, "R3");
    do_cmd(1, 1, 0, 4'd2, 4'd15, 0, 0, 0, 0, 0, 0, "R3");
    do_cmd(1, 1, 3'd2, 4'd3, 4'd1, 0, 0, 0, 0, 0, 0, "R3");
    do_cmd(1, 1, 0, 4'd9, 4'd1, 0, 4'd1, 0, 0, 0, 0, "R3");
    // R10: capture alone, then capture on top of software writes
    do_cmd(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_00F5, 32'hDEAD_0040, "R10");
    do_cmd(1, 1, 0, 4'd5, 4'd1, 0, 0, 0, 0, 0, 0, "R10");
    do_cmd(1, 1, 0, 4'd6, 4'd1, 0, 0, 0, 0, 0, 0, "R10");
    do_cmd(1, 0, 0, 4'd5, 4'd1, 0, 0, 32'h1111_1111, 1, 32'h0000_0022, 32'hC0DE_0000, "R10");
    do_cmd(1, 0, 0, 4'd6, 4'd1, 0, 0, 32'h3333_3333, 1, 32'h0000_0044, 32'hC0DE_0100, "R10");
    do_cmd(1, 1, 0, 4'd5, 4'd1, 0, 0, 0, 0, 0, 0, "R10");
    do_cmd(1, 1, 0, 4'd6, 4'd1, 0, 0, 0, 0, 0, 0, "R10");
    // R11: each enable bit on its own
    do_cmd(1, 0, 0, 4'd1, 4'd1, 0, 0, 32'h0000_0071, 0, 0, 0, "R11");
    do_cmd(1, 0, 0, 4'd1, 4'd1, 0, 0, 32'h0000_0072, 0, 0, 0, "R11");
    do_cmd(1, 0, 0, 4'd1, 4'd1, 0, 0, 32'h0000_0074, 0, 0, 0, "R11");
    do_cmd(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule